// File: doc/BRIEF.md
# GPIO Interrupt Channel Router

This block takes a bank of general-purpose pad inputs and turns up to eight of them into interrupt lines. Each interrupt channel holds its own 8-bit pad index, so software decides which pad drives which interrupt output rather than each pad owning a fixed line. The selected pad is brought into the clock domain by a two-stage synchroniser. An optional inversion then makes it active-low or falling-edge. A glitch filter with a programmable depth comes next. The channel then either drives its output as a level or latches a sticky pending bit on each qualifying edge.

Configuration uses a plain 32-bit word port. A write strobe, a 3-bit word address and write data go in, and read data comes back combinationally for the addressed word. There are five words. Word 0 holds the mode bits and word 1 the filter depths. Words 2 and 3 hold the pad indices. Word 4 is the pending status, which software clears by writing ones. When a channel's pad index, mode or polarity is changed, the channel is flushed and re-baselined, so the change cannot raise an interrupt by itself.

Top module: `gpio_irq_router`

## Requirements
- R1: Word 0 stores the edge-mode bit of channel i at bit i and its invert bit at bit 16+i. Word 1 stores a 4-bit filter depth at bits 4i+3:4i. Word 2 holds 8-bit pad indices for channels 0-3 and word 3 holds them for channels 4-7, each at bits 8(i mod 4)+7:8(i mod 4). Reads return the stored bits. Word 0 reads zero in unused positions, and addresses 5 to 7 read zero.
- R2: Each channel follows exactly the pad named by its own index, independently of all other channels.
- R3: A pad index at or above the implemented pad count gives a constant inactive input, whatever the polarity and mode.
- R4: With filter depth F, a level-mode output changes 2 + max(F,1) clock cycles after the pad changes. F = 0 means no filtering.
- R5: With F >= 2, a pad pulse of F-1 cycles never reaches the output, and a pulse of exactly F cycles does.
- R6: In level mode (edge bit 0) the output follows the filtered input. It is active-high when the invert bit is 0 and active-low when the invert bit is 1.
- R7: In edge mode (edge bit 1), an inactive-to-active transition of the filtered input sets the channel's pending bit, and the output drives that bit. This is a rising pad edge with invert 0 and a falling pad edge with invert 1. The opposite transition sets nothing.
- R8: Word 4 reports the pending bits in bits 7:0. Writing word 4 clears each pending bit whose data bit is 1, and bits written as 0 stay set.
- R9: A write that changes a channel's pad index, edge bit or invert bit clears its pending bit on that write's clock edge. A pad already active when the new setting takes effect raises no edge. A write that changes only the filter depth leaves pending state alone.
- R10: After reset every word reads zero and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one filter sample |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_i | input | NUM_PADS | Asynchronous pad inputs |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the addressed word |
| irq_o | output | NUM_CH | Per-channel interrupt outputs |

## Verification
The hardest case to reach is a reconfiguration that meets a live input. A channel may be re-pointed while its pending bit is set, or switched to edge mode on a pad that is already held active. A mis-ordered flush would then show up either as a stale interrupt or as a spurious edge that appears a few cycles later. The stimulus latches a pending edge first and then rewrites only that channel's index. It then turns on a second channel in edge mode onto a pad that is held high. Last, it changes only the filter word while an edge is pending, to show that this write does not count as a reconfiguration. The filter depth is swept over all sixteen values, and the exact latency and pulse rejection are checked at each depth.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = 8;
    localparam int FILT_W = 4;

    localparam logic [ADDR_W-1:0] ADR_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_FILT   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_SEL_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_SEL_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd4;

    localparam int POL_BASE = 16;

    typedef struct packed {
        logic              edge_md;
        logic              act_low;
        logic [IDX_W-1:0]  sel;
        logic [FILT_W-1:0] depth;
    } chan_cfg_t;

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [REG_W-1:0]         wdata,
    input  logic [NUM_CH-1:0]        pend,
    output logic [REG_W-1:0]         rdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg,
    output logic [NUM_CH-1:0]        reconf,
    output logic [NUM_CH-1:0]        clr
);

    localparam int PER_WORD = REG_W / IDX_W;

    typedef struct packed {
        logic [NUM_CH-1:0]             edge_md;
        logic [NUM_CH-1:0]             act_low;
        logic [NUM_CH-1:0][FILT_W-1:0] depth;
        logic [NUM_CH-1:0][IDX_W-1:0]  sel;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rdata  = '0;
        reconf = '0;
        clr    = '0;

        if (wr_en) begin
            if (addr == ADR_MODE) begin
                st_d.edge_md = wdata[NUM_CH-1:0];
                st_d.act_low = wdata[POL_BASE +: NUM_CH];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == ADR_FILT)
                    st_d.depth[i] = wdata[FILT_W*i +: FILT_W];
                if ((addr == ADR_SEL_LO && i < PER_WORD) ||
                    (addr == ADR_SEL_HI && i >= PER_WORD))
                    st_d.sel[i] = wdata[IDX_W*(i % PER_WORD) +: IDX_W];
                if (addr == ADR_STAT)
                    clr[i] = wdata[i];
            end
        end

        for (int i = 0; i < NUM_CH; i++) begin
            reconf[i] = (st_d.sel[i]     != st_q.sel[i])     ||
                        (st_d.edge_md[i] != st_q.edge_md[i]) ||
                        (st_d.act_low[i] != st_q.act_low[i]);
            cfg[i].edge_md = st_q.edge_md[i];
            cfg[i].act_low = st_q.act_low[i];
            cfg[i].sel     = st_q.sel[i];
            cfg[i].depth   = st_q.depth[i];
        end

        case (addr)
            ADR_MODE: begin
                rdata[NUM_CH-1:0]          = st_q.edge_md;
                rdata[POL_BASE +: NUM_CH]  = st_q.act_low;
            end
            ADR_FILT: for (int i = 0; i < NUM_CH; i++)
                rdata[FILT_W*i +: FILT_W] = st_q.depth[i];
            ADR_SEL_LO: for (int i = 0; i < NUM_CH; i++)
                if (i < PER_WORD) rdata[IDX_W*i +: IDX_W] = st_q.sel[i];
            ADR_SEL_HI: for (int i = 0; i < NUM_CH; i++)
                if (i >= PER_WORD) rdata[IDX_W*(i-PER_WORD) +: IDX_W] = st_q.sel[i];
            ADR_STAT: rdata[NUM_CH-1:0] = pend;
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/gpio_irq_chan.sv
module gpio_irq_chan
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS = 12,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pads,
    input  chan_cfg_t           cfg,
    input  logic                reconf,
    input  logic                clr,
    output logic                pend_o,
    output logic                filt_o,
    output logic                irq_o
);

    localparam int SETTLE_N = SYNC_N + 1;
    localparam int ST_W     = $clog2(SETTLE_N + 1);
    localparam logic [ST_W-1:0] SETTLE = ST_W'(SETTLE_N);

    typedef struct packed {
        logic [SYNC_N-1:0] sync;
        logic              filt;
        logic [FILT_W-1:0] cnt;
        logic [ST_W-1:0]   settle;
        logic              pend;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   raw, samp, rise;

    always_comb begin
        // pad mux: an index with no pad yields the level that reads inactive
        raw = cfg.act_low;
        for (int p = 0; p < NUM_PADS; p++)
            if (cfg.sel == IDX_W'(p)) raw = pads[p];

        samp = st_q.sync[SYNC_N-1] ^ cfg.act_low;

        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_N-2:0], raw};

        if (st_q.settle != '0) begin
            st_d.settle = st_q.settle - 1'b1;
            st_d.cnt    = '0;
            if (st_q.settle == ST_W'(1)) st_d.filt = samp;
        end else if (samp != st_q.filt) begin
            if (st_q.cnt + 1'b1 >= cfg.depth) begin
                st_d.filt = samp;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end

        rise      = (st_q.settle == '0) && st_d.filt && !st_q.filt;
        st_d.pend = (st_q.pend && !clr) || (cfg.edge_md && rise);

        if (reconf) begin
            st_d        = '0;
            st_d.settle = SETTLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.settle <= SETTLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign filt_o = st_q.filt;
    assign irq_o  = cfg.edge_md ? st_q.pend : st_q.filt;

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS = 12,
    parameter int NUM_CH   = 8,
    parameter int SYNC_N   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PADS-1:0] pad_i,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [NUM_CH-1:0]   irq_o
);

    chan_cfg_t [NUM_CH-1:0] cfg_w;
    logic [NUM_CH-1:0]      reconf_w;
    logic [NUM_CH-1:0]      clr_w;
    logic [NUM_CH-1:0]      pend_w;
    logic [NUM_CH-1:0]      filt_w;

    gpio_irq_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend   (pend_w),
        .rdata  (reg_rdata),
        .cfg    (cfg_w),
        .reconf (reconf_w),
        .clr    (clr_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        gpio_irq_chan #(.NUM_PADS(NUM_PADS), .SYNC_N(SYNC_N)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pads   (pad_i),
            .cfg    (cfg_w[c]),
            .reconf (reconf_w[c]),
            .clr    (clr_w[c]),
            .pend_o (pend_w[c]),
            .filt_o (filt_w[c]),
            .irq_o  (irq_o[c])
        );
    end

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS = 12,
    parameter int NUM_CH   = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input chan_cfg_t [NUM_CH-1:0] cfg,
    input logic [NUM_CH-1:0]      reconf,
    input logic [NUM_CH-1:0]      clr,
    input logic [NUM_CH-1:0]      pend,
    input logic [NUM_CH-1:0]      filt
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_a
        assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            reconf[c] |=> !pend[c]);

        assert_pend_drop_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[c]) |-> $past(clr[c] || reconf[c]));

        assert_pend_set_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pend[c]) |-> (cfg[c].edge_md && $rose(filt[c])));

        assert_no_pad_inactive_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg[c].sel) >= NUM_PADS) |-> !filt[c]);
    end

endmodule

bind gpio_irq_router gpio_irq_router_chk #(.NUM_PADS(NUM_PADS), .NUM_CH(NUM_CH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg    (cfg_w),
    .reconf (reconf_w),
    .clr    (clr_w),
    .pend   (pend_w),
    .filt   (filt_w)
);

// File: tb/tb_gpio_irq_router.sv
module tb_gpio_irq_router;
    import gpio_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NPADS      = 12;
    localparam int NCH        = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPADS-1:0] pad_i = '0;
    logic             reg_wr_en = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NCH-1:0]   irq_o;

    int tests = 0;
    int fails = 0;

    logic [7:0] sh_sel  [NCH];
    logic       sh_edge [NCH];
    logic       sh_pol  [NCH];
    logic [3:0] sh_dep  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_router #(.NUM_PADS(NPADS), .NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .pad_i(pad_i), .reg_wr_en(reg_wr_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic apply_cfg();
        logic [31:0] m, f, lo, hi;
        m = '0; f = '0; lo = '0; hi = '0;
        for (int i = 0; i < NCH; i++) begin
            m[i] = sh_edge[i]; m[16+i] = sh_pol[i];
            f[4*i +: 4] = sh_dep[i];
            if (i < 4) lo[8*i +: 8] = sh_sel[i]; else hi[8*(i-4) +: 8] = sh_sel[i];
        end
        reg_write(3'd0, m);
        reg_write(3'd1, f);
        reg_write(3'd2, lo);
        reg_write(3'd3, hi);
        idle(6);
    endtask

    task automatic set_ch0(input logic [7:0] s, input logic e, input logic p, input logic [3:0] d);
        sh_sel[0] = s; sh_edge[0] = e; sh_pol[0] = p; sh_dep[0] = d;
        apply_cfg();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [NCH-1:0] exp_v;
        bit seen;
        int lat;

        for (int i = 0; i < NCH; i++) begin
            sh_sel[i] = '0; sh_edge[i] = 1'b0; sh_pol[i] = 1'b0; sh_dep[i] = '0;
        end
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R10: reset state
        for (int a = 0; a < 8; a++) begin
            reg_read(3'(a), rd);
            chk(rd == 0, "R10 reset word", rd, 0);
        end
        chk(irq_o == 0, "R10 reset irq", 32'(irq_o), 0);

        // R1: storage and readback
        reg_write(3'd0, 32'hFFFF_FFFF);
        reg_read(3'd0, rd); chk(rd == 32'h00FF_00FF, "R1 mode word", rd, 32'h00FF_00FF);
        reg_write(3'd1, 32'hFEDC_BA98);
        reg_read(3'd1, rd); chk(rd == 32'hFEDC_BA98, "R1 filter word", rd, 32'hFEDC_BA98);
        reg_write(3'd2, 32'h0302_0100);
        reg_read(3'd2, rd); chk(rd == 32'h0302_0100, "R1 select low", rd, 32'h0302_0100);
        reg_write(3'd3, 32'hFF0B_0A09);
        reg_read(3'd3, rd); chk(rd == 32'hFF0B_0A09, "R1 select high", rd, 32'hFF0B_0A09);
        reg_read(3'd6, rd); chk(rd == 0, "R1 unused address", rd, 0);
        apply_cfg();
        reg_read(3'd4, rd); chk(rd == 0, "R9 no pending after restore", rd, 0);

        // R4 R5 R6: filter depth sweep, channel 0 on pad 3, level active-high
        for (int f = 0; f < 16; f++) begin
            set_ch0(8'd3, 1'b0, 1'b0, 4'(f));
            lat = 2 + ((f == 0) ? 1 : f);
            pad_i[3] = 1'b1;
            for (int n = 1; n <= lat; n++) begin
                @(negedge clk);
                if (n == lat - 1) chk(irq_o[0] == 1'b0, "R4 rise not early", 32'(irq_o[0]), 0);
                if (n == lat)     chk(irq_o[0] == 1'b1, "R4 rise latency", 32'(irq_o[0]), 1);
            end
            pad_i[3] = 1'b0;
            for (int n = 1; n <= lat; n++) begin
                @(negedge clk);
                if (n == lat - 1) chk(irq_o[0] == 1'b1, "R4 fall not early", 32'(irq_o[0]), 1);
                if (n == lat)     chk(irq_o[0] == 1'b0, "R6 fall latency", 32'(irq_o[0]), 0);
            end
            if (f >= 2) begin
                pad_i[3] = 1'b1; idle(f - 1); pad_i[3] = 1'b0;
                seen = 1'b0;
                for (int n = 0; n < 2*f + 6; n++) begin @(negedge clk); if (irq_o[0]) seen = 1'b1; end
                chk(!seen, "R5 short pulse rejected", 32'(seen), 0);
                pad_i[3] = 1'b1; idle(f); pad_i[3] = 1'b0;
                seen = 1'b0;
                for (int n = 0; n < 2*f + 6; n++) begin @(negedge clk); if (irq_o[0]) seen = 1'b1; end
                chk(seen, "R5 full pulse passes", 32'(seen), 1);
            end
        end

        // R6: active-low level
        set_ch0(8'd3, 1'b0, 1'b1, 4'd0);
        chk(irq_o[0] == 1'b1, "R6 active-low idle pad", 32'(irq_o[0]), 1);
        pad_i[3] = 1'b1; idle(3);
        chk(irq_o[0] == 1'b0, "R6 active-low released", 32'(irq_o[0]), 0);
        pad_i[3] = 1'b0; idle(4);

        // R7 R8: rising edge, sticky, write-one-to-clear
        set_ch0(8'd3, 1'b1, 1'b0, 4'd0);
        pad_i[3] = 1'b1;
        for (int n = 1; n <= 3; n++) begin
            @(negedge clk);
            if (n == 1) pad_i[3] = 1'b0;
            if (n == 2) chk(irq_o[0] == 1'b0, "R7 edge not early", 32'(irq_o[0]), 0);
            if (n == 3) chk(irq_o[0] == 1'b1, "R7 edge latency", 32'(irq_o[0]), 1);
        end
        idle(5);
        chk(irq_o[0] == 1'b1, "R7 sticky after pad low", 32'(irq_o[0]), 1);
        reg_read(3'd4, rd); chk(rd == 32'h1, "R8 status word", rd, 32'h1);
        reg_write(3'd4, 32'hFFFF_FFFE);
        reg_read(3'd4, rd); chk(rd == 32'h1, "R8 zero bit keeps pending", rd, 32'h1);
        reg_write(3'd4, 32'h1);
        chk(irq_o[0] == 1'b0, "R8 clear irq", 32'(irq_o[0]), 0);
        reg_read(3'd4, rd); chk(rd == 0, "R8 clear status", rd, 0);

        // R7: falling edge with invert
        pad_i[3] = 1'b1;
        set_ch0(8'd3, 1'b1, 1'b1, 4'd0);
        reg_read(3'd4, rd); chk(rd == 0, "R9 no edge on config", rd, 0);
        pad_i[3] = 1'b0; idle(4);
        chk(irq_o[0] == 1'b1, "R7 falling edge", 32'(irq_o[0]), 1);
        reg_write(3'd4, 32'h1);
        pad_i[3] = 1'b1; idle(5);
        chk(irq_o[0] == 1'b0, "R7 rising ignored when inverted", 32'(irq_o[0]), 0);
        pad_i[3] = 1'b0; idle(4);
        reg_write(3'd4, 32'hFF);

        // R3: indices without a pad
        set_ch0(8'd12, 1'b0, 1'b1, 4'd0);
        chk(irq_o[0] == 1'b0, "R3 index 12 inverted low", 32'(irq_o[0]), 0);
        pad_i = '1; idle(4);
        chk(irq_o[0] == 1'b0, "R3 index 12 pads high", 32'(irq_o[0]), 0);
        pad_i = '0;
        set_ch0(8'd255, 1'b1, 1'b0, 4'd0);
        pad_i = '1; idle(4); pad_i = '0; idle(4);
        reg_read(3'd4, rd); chk(rd == 0, "R3 index 255 no edge", rd, 0);
        set_ch0(8'd11, 1'b0, 1'b0, 4'd0);
        pad_i[11] = 1'b1; idle(4);
        chk(irq_o[0] == 1'b1, "R3 last real pad", 32'(irq_o[0]), 1);
        pad_i = '0;

        // R2: routing sweep across all channels and pads
        for (int c = 0; c < NCH; c++) begin
            sh_sel[c] = 8'((c + 5) % NPADS); sh_edge[c] = 1'b0; sh_pol[c] = 1'b0; sh_dep[c] = '0;
        end
        apply_cfg();
        for (int p = 0; p < NPADS; p++) begin
            pad_i = NPADS'(1) << p;
            idle(4);
            for (int c = 0; c < NCH; c++) exp_v[c] = (((c + 5) % NPADS) == p);
            chk(irq_o == exp_v, "R2 routing", 32'(irq_o), 32'(exp_v));
        end
        pad_i = '0; idle(4);

        // R9: reconfiguration flushes state
        for (int c = 0; c < NCH; c++) begin
            sh_sel[c] = '0; sh_edge[c] = 1'b0; sh_pol[c] = 1'b0; sh_dep[c] = '0;
        end
        set_ch0(8'd3, 1'b1, 1'b0, 4'd0);
        pad_i[3] = 1'b1; idle(1); pad_i[3] = 1'b0; idle(4);
        chk(irq_o[0] == 1'b1, "R9 pending before flush", 32'(irq_o[0]), 1);
        sh_sel[0] = 8'd4;
        reg_write(3'd2, {8'd0, 8'd0, 8'd0, 8'd4});
        chk(irq_o[0] == 1'b0, "R9 index change clears", 32'(irq_o[0]), 0);
        idle(6);
        pad_i[6] = 1'b1;
        sh_sel[1] = 8'd6; sh_edge[1] = 1'b1;
        apply_cfg();
        reg_read(3'd4, rd); chk(rd == 0, "R9 active pad no edge", rd, 0);
        pad_i[6] = 1'b0;
        pad_i[4] = 1'b1; idle(1); pad_i[4] = 1'b0; idle(4);
        chk(irq_o[0] == 1'b1, "R9 pending again", 32'(irq_o[0]), 1);
        reg_write(3'd1, 32'h0000_0005);
        idle(2);
        chk(irq_o[0] == 1'b1, "R9 depth write keeps pending", 32'(irq_o[0]), 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule